// File: doc/BRIEF.md
# Programmable Chip-Select Unit with Interrupt-Acknowledge Decode

This block drives a set of chip-select lines for a 24-bit address bus. Each channel holds a base register (the upper address bits plus a block-size code) and an option register (byte lanes, transfer direction, interrupt level, autovector enable). It also holds a 2-bit pin-function field. The low bit of that field comes out of reset as one, and the high bit is sampled from a strap data line while reset is held. When a bus cycle starts, every channel compares the cycle against its settings. One clock later the block raises the chip-select of every matching channel, together with a one-cycle termination. The termination is either a data-size acknowledge (8-bit or 16-bit port) or an autovector strobe.

Processor CPU-space cycles are treated as interrupt acknowledges. In such a cycle, address bits 19:16 carry the all-ones cycle type, bits 3:1 carry the priority level, and all other low-order bits are ones. A channel answers an acknowledge only when all of the following hold:
- its base bits 19:16 are all ones;
- its block is 64 KB or smaller;
- it is set to read-only;
- its byte field selects the lane the vector travels on;
- its level field equals the acknowledged level;
- the interrupt controller flags the request as coming from an external pin.

When the request comes from an internal source, that source supplies its own vector and acknowledge, and the block stays silent.

Top module: `cs_unit`

## Requirements
- R1: While reset is held, each channel's pin-function field becomes {strap_data[i], 1}, and cs_o, dsack_o and avec_o are 0. The field is visible on pin_func_o[2i+1:2i].
- R2: A channel asserts nothing until both its base register (select 0) and its option register (select 1) have been written since reset. The option byte field resets to 0, which means disabled.
- R3: In a normal cycle (cyc_cpu_space=0), the address matches when cyc_addr[23:S] equals the base field over the same bits. The base field sits in base register bits 15:3 and holds address bits 23:11. S comes from the block-size code in bits 2:0, as follows: 0→11, 1→13, 2→14, 3→16, 4→17, 5→18, 6→19, 7→20.
- R4: The direction field (option bits 3:2) works as follows in normal cycles: 0 blocks every cycle, 1 allows reads only, 2 allows writes only, 3 allows both.
- R5: The byte field (option bits 1:0) works as follows in normal cycles: 0 never matches, 1 needs cyc_lane_lo, 2 needs cyc_lane_hi, 3 needs either lane.
- R6: Pin-function codes (select 2, data bits 1:0) are: 0 general output, 1 alternate function, 2 chip-select on an 8-bit port, 3 chip-select on a 16-bit port. Only codes 2 and 3 assert cs_o. dsack_o is 2'b01 for an 8-bit port and 2'b10 for a 16-bit port, and never 2'b11.
- R7: Outputs appear exactly one clock after a cycle with cyc_start=1 and last one clock. dsack_o and avec_o are never active together.
- R8: An interrupt-acknowledge cycle has cyc_cpu_space=1, cyc_addr[19:4] all ones and cyc_addr[0]=1. A channel matches it only under all of these conditions: base bits 19:16 (register bits 11:8) are all ones, the block code is 3 or less, the direction is 1, cyc_read=1, and cyc_addr[3:1] equals the level field (option bits 7:5). Other CPU-space cycles never match.
- R9: In an acknowledge, a 16-bit-port channel must have byte field 1 and an 8-bit-port channel must have byte field 2. The lane inputs are not used.
- R10: With ext_irq_source=0, an acknowledge produces no chip-select and no termination.
- R11: A matching acknowledge on a channel with autovector enabled (option bit 4) pulses avec_o with dsack_o=0. In normal cycles, bit 4 has no effect.
- R12: cs_o is asserted for every matching channel. The termination comes from the lowest-numbered matching channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap lines are sampled while it is low |
| strap_data | input | NUM_CS | Data-line levels giving the pin-function high bits at reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 base, 1 option, 2 pin function |
| reg_wr_chan | input | CH_W | Target channel |
| reg_wr_data | input | 16 | Write data |
| cyc_start | input | 1 | Start of a bus cycle |
| cyc_addr | input | 24 | Cycle address |
| cyc_read | input | 1 | 1 for a read cycle |
| cyc_cpu_space | input | 1 | 1 for a CPU-space cycle |
| cyc_lane_hi | input | 1 | Upper byte lane active |
| cyc_lane_lo | input | 1 | Lower byte lane active |
| ext_irq_source | input | 1 | Pending acknowledge belongs to an external pin request |
| cs_o | output | NUM_CS | Chip-select per channel, active high |
| dsack_o | output | 2 | Size acknowledge: 01 8-bit, 10 16-bit |
| avec_o | output | 1 | Autovector strobe |
| pin_func_o | output | 2*NUM_CS | Current pin-function fields |

## Verification
The checker watches these properties on every cycle:
- outputs appear only one cycle after a cycle start;
- the size code is legal and never occurs together with an autovector;
- a chip-select only appears on a pin assigned as a chip-select;
- an internally sourced acknowledge yields nothing;
- an autovector only follows a read in CPU space.

The address window per block size, the direction and lane tables, the strapping, and the requirement that both registers be written can only be shown by the bench's sweeps. The same holds for level matching, the lane rule for acknowledges, and lowest-channel priority. The bench compares each of these against values it computes itself.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int ADDR_W      = 24;
    localparam int DATA_W      = 16;
    localparam int PAGE_LSB    = 11;
    localparam int BASE_W      = ADDR_W - PAGE_LSB;
    localparam int IACK_TYPE_HI = 19;
    localparam int LVL_W       = 3;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2,
        LANE_BOTH = 2'd3
    } lane_sel_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2,
        DIR_ANY  = 2'd3
    } dir_sel_e;

    typedef enum logic [1:0] {
        PIN_GPIO = 2'd0,
        PIN_ALT  = 2'd1,
        PIN_CS8  = 2'd2,
        PIN_CS16 = 2'd3
    } pin_fn_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_OPT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam logic [1:0] SIZE_NONE = 2'b00;
    localparam logic [1:0] SIZE_8    = 2'b01;
    localparam logic [1:0] SIZE_16   = 2'b10;

    typedef struct packed {
        logic [BASE_W-1:0] addr;
        logic [2:0]        blk;
    } base_reg_t;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             autovec;
        dir_sel_e         dir;
        lane_sel_e        lanes;
    } opt_reg_t;

    localparam int OPT_W = $bits(opt_reg_t);

    function automatic int unsigned blk_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 11;
            3'd1:    return 13;
            3'd2:    return 14;
            3'd3:    return 16;
            3'd4:    return 17;
            3'd5:    return 18;
            3'd6:    return 19;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/cs_chan_match.sv
module cs_chan_match
    import cs_pkg::*;
(
    input  base_reg_t          base,
    input  opt_reg_t           opt,
    input  pin_fn_e            pin,
    input  logic               armed,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               cpu_space,
    input  logic               lane_hi,
    input  logic               lane_lo,
    input  logic               ext_src,
    output logic               hit,
    output logic               auto_hit,
    output logic               wide
);
    logic [BASE_W-1:0] cmp_mask;
    logic              addr_ok;
    logic              dir_ok;
    logic              lane_ok;
    logic              pin_cs;
    logic              norm_hit;
    logic              iack_cyc;
    logic              iack_cfg;
    logic              iack_hit;
    lane_sel_e         vec_lane;

    always_comb begin
        for (int j = 0; j < BASE_W; j++) begin
            cmp_mask[j] = (j + PAGE_LSB) >= int'(blk_shift(base.blk));
        end
    end

    assign addr_ok = ((addr[ADDR_W-1:PAGE_LSB] ^ base.addr) & cmp_mask) == '0;

    always_comb begin
        case (opt.dir)
            DIR_RD:  dir_ok = rd;
            DIR_WR:  dir_ok = !rd;
            DIR_ANY: dir_ok = 1'b1;
            default: dir_ok = 1'b0;
        endcase
        case (opt.lanes)
            LANE_LO:   lane_ok = lane_lo;
            LANE_HI:   lane_ok = lane_hi;
            LANE_BOTH: lane_ok = lane_hi | lane_lo;
            default:   lane_ok = 1'b0;
        endcase
    end

    assign pin_cs   = (pin == PIN_CS8) || (pin == PIN_CS16);
    assign wide     = (pin == PIN_CS16);
    assign vec_lane = wide ? LANE_LO : LANE_HI;
    assign norm_hit = !cpu_space && addr_ok && dir_ok && lane_ok;

    assign iack_cyc = cpu_space && (&addr[IACK_TYPE_HI:4]) && addr[0];
    assign iack_cfg = (&base.addr[IACK_TYPE_HI-PAGE_LSB -: 4])
                   && (base.blk <= 3'd3)
                   && (opt.dir == DIR_RD)
                   && rd
                   && (opt.lanes == vec_lane)
                   && (addr[3:1] == opt.lvl)
                   && ext_src;
    assign iack_hit = iack_cyc && iack_cfg;

    assign hit      = armed && pin_cs && (norm_hit || iack_hit);
    assign auto_hit = armed && pin_cs && iack_hit && opt.autovec;

endmodule

// File: rtl/cs_term_sel.sv
module cs_term_sel
    import cs_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic [NUM_CS-1:0] hit,
    input  logic [NUM_CS-1:0] auto_hit,
    input  logic [NUM_CS-1:0] wide,
    output logic [1:0]        size_ack,
    output logic              avec
);
    always_comb begin
        size_ack = SIZE_NONE;
        avec     = 1'b0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                avec     = auto_hit[i];
                size_ack = auto_hit[i] ? SIZE_NONE : (wide[i] ? SIZE_16 : SIZE_8);
            end
        end
    end
endmodule

// File: rtl/cs_unit.sv
module cs_unit
    import cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CH_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CS-1:0]     strap_data,
    input  logic                  reg_wr_en,
    input  logic [1:0]            reg_wr_sel,
    input  logic [CH_W-1:0]       reg_wr_chan,
    input  logic [DATA_W-1:0]     reg_wr_data,
    input  logic                  cyc_start,
    input  logic [ADDR_W-1:0]     cyc_addr,
    input  logic                  cyc_read,
    input  logic                  cyc_cpu_space,
    input  logic                  cyc_lane_hi,
    input  logic                  cyc_lane_lo,
    input  logic                  ext_irq_source,
    output logic [NUM_CS-1:0]     cs_o,
    output logic [1:0]            dsack_o,
    output logic                  avec_o,
    output logic [2*NUM_CS-1:0]   pin_func_o
);
    typedef struct packed {
        base_reg_t [NUM_CS-1:0]  base;
        opt_reg_t  [NUM_CS-1:0]  opt;
        logic [NUM_CS-1:0][1:0]  pin;
        logic [NUM_CS-1:0]       base_wr;
        logic [NUM_CS-1:0]       opt_wr;
        logic [NUM_CS-1:0]       cs;
        logic [1:0]              dsack;
        logic                    avec;
    } state_t;

    state_t st_d, st_q, st_rst;

    logic [NUM_CS-1:0] hit_vec;
    logic [NUM_CS-1:0] auto_vec;
    logic [NUM_CS-1:0] wide_vec;
    logic [1:0]        term_size;
    logic              term_avec;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_chan
        cs_chan_match i_match (
            .base      (st_q.base[g]),
            .opt       (st_q.opt[g]),
            .pin       (pin_fn_e'(st_q.pin[g])),
            .armed     (st_q.base_wr[g] & st_q.opt_wr[g]),
            .addr      (cyc_addr),
            .rd        (cyc_read),
            .cpu_space (cyc_cpu_space),
            .lane_hi   (cyc_lane_hi),
            .lane_lo   (cyc_lane_lo),
            .ext_src   (ext_irq_source),
            .hit       (hit_vec[g]),
            .auto_hit  (auto_vec[g]),
            .wide      (wide_vec[g])
        );
        assign pin_func_o[2*g +: 2] = st_q.pin[g];
    end

    cs_term_sel #(.NUM_CS(NUM_CS)) i_term (
        .hit      (hit_vec),
        .auto_hit (auto_vec),
        .wide     (wide_vec),
        .size_ack (term_size),
        .avec     (term_avec)
    );

    always_comb begin
        st_rst = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            st_rst.pin[i] = {strap_data[i], 1'b1};
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.cs    = '0;
        st_d.dsack = SIZE_NONE;
        st_d.avec  = 1'b0;
        if (reg_wr_en) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (reg_wr_chan == CH_W'(i)) begin
                    case (reg_sel_e'(reg_wr_sel))
                        SEL_BASE: begin
                            st_d.base[i]    = base_reg_t'(reg_wr_data);
                            st_d.base_wr[i] = 1'b1;
                        end
                        SEL_OPT: begin
                            st_d.opt[i]    = opt_reg_t'(reg_wr_data[OPT_W-1:0]);
                            st_d.opt_wr[i] = 1'b1;
                        end
                        SEL_PIN:  st_d.pin[i] = reg_wr_data[1:0];
                        default:  ;
                    endcase
                end
            end
        end
        if (cyc_start) begin
            st_d.cs    = hit_vec;
            st_d.dsack = term_size;
            st_d.avec  = term_avec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign cs_o    = st_q.cs;
    assign dsack_o = st_q.dsack;
    assign avec_o  = st_q.avec;

endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk #(
    parameter int NUM_CS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cyc_start,
    input logic                cyc_cpu_space,
    input logic                cyc_read,
    input logic                ext_irq_source,
    input logic [NUM_CS-1:0]   cs_o,
    input logic [1:0]          dsack_o,
    input logic                avec_o,
    input logic [2*NUM_CS-1:0] pin_func_o
);
    AST_TERM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(avec_o && dsack_o != 2'b00)); // R7

    AST_OUT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs_o || |dsack_o || avec_o) |-> $past(cyc_start)); // R7

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_o != 2'b11); // R6

    AST_INT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cyc_start && cyc_cpu_space && !ext_irq_source)
        |-> (cs_o == '0 && !avec_o && dsack_o == 2'b00)); // R10

    AST_AVEC_IACK: assert property (@(posedge clk) disable iff (!rst_n)
        avec_o |-> $past(cyc_start && cyc_cpu_space && cyc_read && ext_irq_source)); // R11

    AST_CS_TERMINATED: assert property (@(posedge clk) disable iff (!rst_n)
        |cs_o |-> (dsack_o != 2'b00 || avec_o)); // R12

    for (genvar g = 0; g < NUM_CS; g++) begin : g_pin
        AST_CS_PIN_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
            cs_o[g] |-> $past(pin_func_o[2*g+1])); // R6
    end
endmodule

bind cs_unit cs_unit_chk #(.NUM_CS(NUM_CS)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cyc_start      (cyc_start),
    .cyc_cpu_space  (cyc_cpu_space),
    .cyc_read       (cyc_read),
    .ext_irq_source (ext_irq_source),
    .cs_o           (cs_o),
    .dsack_o        (dsack_o),
    .avec_o         (avec_o),
    .pin_func_o     (pin_func_o)
);

// File: tb/test_cs_unit.sv
module test_cs_unit;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] strap_data = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [1:0]  reg_wr_chan = '0;
    logic [15:0] reg_wr_data = '0;
    logic        cyc_start = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic        cyc_read = 1'b0;
    logic        cyc_cpu_space = 1'b0;
    logic        cyc_lane_hi = 1'b0;
    logic        cyc_lane_lo = 1'b0;
    logic        ext_irq_source = 1'b0;
    logic [N-1:0]   cs_o;
    logic [1:0]     dsack_o;
    logic           avec_o;
    logic [2*N-1:0] pin_func_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [15:0] m_base [N];
    logic [7:0]  m_opt  [N];
    logic [1:0]  m_pin  [N];
    logic [N-1:0] m_bw, m_ow;

    cs_unit #(.NUM_CS(N)) i_cs_unit (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int sh(input logic [2:0] c);
        case (c)
            3'd0: return 11; 3'd1: return 13; 3'd2: return 14; 3'd3: return 16;
            3'd4: return 17; 3'd5: return 18; 3'd6: return 19; default: return 20;
        endcase
    endfunction

    function automatic logic [6:0] model(input logic [23:0] a, input logic rd, cpu, hi, lo, ext);
        logic [3:0] ecs = '0;
        logic [1:0] eds = '0;
        logic       eav = 1'b0;
        logic       found = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic [23:0] ba;
            logic [1:0] dir, ln;
            logic dok, lok, nh, ih, ic, h;
            int s;
            ba  = {m_base[i][15:3], 11'b0};
            s   = sh(m_base[i][2:0]);
            dir = m_opt[i][3:2];
            ln  = m_opt[i][1:0];
            dok = (dir == 3) || (dir == 1 && rd) || (dir == 2 && !rd);
            lok = (ln == 3) ? (hi | lo) : (ln == 1) ? lo : (ln == 2) ? hi : 1'b0;
            nh  = !cpu && ((a >> s) == (ba >> s)) && dok && lok;
            ic  = cpu && (a[19:4] == 16'hFFFF) && a[0];
            ih  = ic && (m_base[i][11:8] == 4'hF) && (m_base[i][2:0] <= 3) && (dir == 1) && rd
                  && (ln == ((m_pin[i] == 2'd3) ? 2'd1 : 2'd2)) && (a[3:1] == m_opt[i][7:5]) && ext;
            h   = m_bw[i] && m_ow[i] && m_pin[i][1] && (nh || ih);
            ecs[i] = h;
            if (h && !found) begin
                found = 1'b1;
                eav = ih && m_opt[i][4];
                eds = eav ? 2'b00 : (m_pin[i][0] ? 2'b10 : 2'b01);
            end
        end
        return {ecs, eds, eav};
    endfunction

    task automatic do_reset(input logic [N-1:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_data = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0; m_opt[i] = '0; m_pin[i] = {strap[i], 1'b1};
        end
        m_bw = '0; m_ow = '0;
    endtask

    task automatic wr(input logic [1:0] sel, input int ch, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_chan = 2'(ch); reg_wr_data = d;
        case (sel)
            2'd0: begin m_base[ch] = d; m_bw[ch] = 1'b1; end
            2'd1: begin m_opt[ch] = d[7:0]; m_ow[ch] = 1'b1; end
            2'd2: m_pin[ch] = d[1:0];
            default: ;
        endcase
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic cyc(input string tag, input logic [23:0] a, input logic rd, cpu, hi, lo, ext);
        logic [6:0] e;
        e = model(a, rd, cpu, hi, lo, ext);
        @(negedge clk);
        cyc_addr = a; cyc_read = rd; cyc_cpu_space = cpu;
        cyc_lane_hi = hi; cyc_lane_lo = lo; ext_irq_source = ext;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk(tag, {25'b0, cs_o, dsack_o, avec_o}, {25'b0, e});
        @(negedge clk);
        chk("R7 one-cycle pulse", {25'b0, cs_o, dsack_o, avec_o}, 32'b0);
    endtask

    function automatic logic [7:0] pin_exp();
        logic [7:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = m_pin[i];
        return v;
    endfunction

    localparam logic [23:0] B = 24'hA00000;

    initial begin
        // R1: strapping and quiet outputs at reset
        do_reset(4'b1010);
        @(negedge clk);
        chk("R1 strap 1010", {24'b0, pin_func_o}, {24'b0, 8'b11_01_11_01});
        chk("R1 outputs idle", {25'b0, cs_o, dsack_o, avec_o}, 32'b0);

        // R6: pin assignments written
        wr(2'd2, 0, 16'd3); wr(2'd2, 1, 16'd2); wr(2'd2, 2, 16'd1); wr(2'd2, 3, 16'd0);
        chk("R6 pin readback", {24'b0, pin_func_o}, {24'b0, pin_exp()});

        // R2: nothing before both registers are written
        cyc("R2 unwritten", 24'h000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        wr(2'd1, 0, 16'h000F);
        cyc("R2 option only", 24'h000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        wr(2'd0, 0, 16'h0000);
        cyc("R2 both written", 24'h000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

        // R3: block size windows
        for (int c = 0; c < 8; c++) begin
            int s;
            s = sh(3'(c));
            wr(2'd0, 0, {B[23:11], 3'(c)});
            cyc("R3 base", B, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            cyc("R3 top of block", B + (24'd1 << s) - 24'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            cyc("R3 past block", B + (24'd1 << s), 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            cyc("R3 below base", B - 24'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        end

        // R4/R5: direction and lane sweep (R11: autovec bit set, normal cycles)
        for (int d = 0; d < 4; d++)
            for (int l = 0; l < 4; l++) begin
                wr(2'd1, 0, {8'h00, 3'd0, 1'b1, 2'(d), 2'(l)});
                for (int r = 0; r < 2; r++)
                    for (int ln = 1; ln < 4; ln++)
                        cyc("R4 R5 R11 dir/lane", B + 24'h10, 1'(r), 1'b0, ln[1], ln[0], 1'b1);
            end

        // R12 and R6: shared window, priority and pin roles
        for (int i = 0; i < N; i++) begin
            wr(2'd0, i, {B[23:11], 3'd7});
            wr(2'd1, i, 16'h000F);
        end
        cyc("R12 two hits, ch0 wins", B + 24'h400, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        wr(2'd1, 0, 16'h000C);
        cyc("R12 ch0 off, ch1 sizes", B + 24'h400, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        for (int p = 0; p < 4; p++) begin
            wr(2'd2, 1, 16'(p));
            cyc("R6 pin role sweep", B + 24'h400, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        end
        wr(2'd2, 1, 16'd2);

        // R8..R11: interrupt acknowledge
        wr(2'd0, 0, 16'hFFFB); wr(2'd1, 0, 16'h00A5);
        wr(2'd0, 1, 16'hFFF8); wr(2'd1, 1, 16'h0056);
        for (int lv = 0; lv < 8; lv++)
            for (int x = 0; x < 2; x++)
                for (int r = 0; r < 2; r++)
                    cyc("R8 R10 R11 iack sweep", 24'hFFFFF1 | (24'(lv) << 1),
                        1'(r), 1'b1, 1'b0, 1'b0, 1'(x));
        wr(2'd0, 0, 16'hFFFC);
        cyc("R8 block above 64K", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd0, 0, 16'hFFFB);
        cyc("R8 level 5 restored", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd1, 0, 16'h00A6);
        cyc("R9 16-bit port wrong lane", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd1, 0, 16'h00AD);
        cyc("R8 not read-only", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd1, 0, 16'h00B5);
        cyc("R11 autovector ch0", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc("R10 internal source", 24'hFFFFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R8 other cpu space", 24'hF0FFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd1, 1, 16'h0055);
        cyc("R9 8-bit port wrong lane", 24'hFFFFF5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd1, 1, 16'h0056);
        cyc("R11 normal read, ch1 only", 24'hFFF800, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc("R12 normal read, both", 24'hFFF800, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

        // R1/R2: second reset with other strapping
        do_reset(4'b0101);
        @(negedge clk);
        chk("R1 strap 0101", {24'b0, pin_func_o}, {24'b0, 8'b01_11_01_11});
        cyc("R2 after reset", 24'hFFF800, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule